// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

A synthesizable behavioural model of a synchronous static RAM that moves data on both halves of its command clock and uses one shared data bus for reads and writes. Every command moves a burst of two words. The first word is at the addressed location. The second word is at the same address with its least significant bit inverted. Both words use the address latched when the command was taken.

The model runs on one beat clock that is twice the command rate. Each beat-clock edge stands for one edge of the command clock: alternately a rising edge, where commands are sampled, and a falling edge. An internal phase register tracks which kind of edge comes next. After reset, the first edge is a rising one. Read data appears one command cycle after the read. Write data is taken from the bus one command cycle after the write. Each write beat carries active-low byte enables, one per 9-bit byte. A stop request lets pending work finish and then freezes the block, bus included, until the request is released.

Top module: `b2sram_top`

## Requirements
- R1: While reset is high and on the first beat after it, bus_oe is low, and the first beat edge after reset is a command edge.
- R2: A command edge with cmd_load_n high is a no-operation, and bus_oe is low on both beats of the next command cycle.
- R3: cmd_load_n low with cmd_read high at command edge n starts a read. From beat edge n+2, bus_out holds the word at the latched address and bus_oe is high.
- R4: cmd_load_n low with cmd_read low at command edge n starts a write. bus_in is stored at edge n+2 (first word) and at edge n+3 (second word). bus_oe stays low on those beats.
- R5: wr_byte_n[i] covers bus bits 9*i+8 down to 9*i and is sampled with each write beat. Low writes that byte, and high leaves the stored byte unchanged. Any subset of bytes may be written.
- R6: The second beat of a burst, at edge n+3, uses the latched address with bit 0 inverted. Address changes after the command edge have no effect.
- R7: A read issued in the command cycle right after a write to the same address returns the newly written bytes.
- R8: cmd_load_n is ignored on the edges between command edges.
- R9: stop_req high at a command edge blocks new commands. Once no command is pending at a command edge, the block freezes: bus_out and bus_oe hold their values and commands are ignored. The first edge after stop_req falls is a command edge.
- R10: Reads in consecutive command cycles keep bus_oe high across all their beats. bus_oe falls on the first beat after the last read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst | input | 1 | Synchronous reset, active high |
| cmd_load_n | input | 1 | Active-low command strobe |
| cmd_read | input | 1 | High selects read, low selects write |
| stop_req | input | 1 | Request to drain and freeze |
| addr | input | AW | Burst address |
| bus_in | input | DW | Write data beat from the shared bus |
| wr_byte_n | input | DW/9 | Active-low byte write enables for the current beat |
| bus_out | output | DW | Read data beat |
| bus_oe | output | 1 | High while the block drives the bus |

## Verification
The assertions assume that the environment never drives write data while bus_oe is high. They also assume that a location has been fully written before it is partially written, so the stored value stays defined. Every bench task starts a command cycle from the beat after a command edge, so the phase stays aligned. Write data is always placed in the command cycle after its write. Reads of a location come only after that location has been fully written. The stop request changes only at command edges, so it always meets the block at the phase where it is sampled.

// File: rtl/b2sram_pkg.sv
package b2sram_pkg;

    localparam int BYTE_W = 9;

    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } op_e;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    function automatic int lane_count(input int dw);
        return dw / BYTE_W;
    endfunction

endpackage

// File: rtl/b2sram_ctrl.sv
module b2sram_ctrl
    import b2sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_load_n,
    input  logic          cmd_read,
    input  logic          stop_req,
    input  logic [AW-1:0] addr,
    output logic          beat_vld,
    output op_e           beat_op,
    output logic [AW-1:0] beat_addr,
    output logic          hold
);

    typedef struct packed {
        logic          vld;
        op_e           op;
        logic [AW-1:0] addr;
    } cmd_t;

    localparam logic [AW-1:0] LSB_FLIP = {{(AW-1){1'b0}}, 1'b1};

    phase_e phase_q;
    cmd_t   cmd_q;
    cmd_t   act_q;

    // freeze only at a command edge with nothing waiting for its first beat
    assign hold = (phase_q == PH_RISE) && stop_req && !cmd_q.vld;

    always_comb begin
        if (phase_q == PH_RISE) begin
            beat_vld  = cmd_q.vld;
            beat_op   = cmd_q.op;
            beat_addr = cmd_q.addr;
        end else begin
            beat_vld  = act_q.vld;
            beat_op   = act_q.op;
            beat_addr = act_q.addr ^ LSB_FLIP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RISE;
            cmd_q   <= '0;
            act_q   <= '0;
        end else if (!hold) begin
            if (phase_q == PH_RISE) begin
                phase_q    <= PH_FALL;
                act_q      <= cmd_q;
                cmd_q.vld  <= !cmd_load_n && !stop_req;
                cmd_q.op   <= cmd_read ? OP_RD : OP_WR;
                cmd_q.addr <= addr;
            end else begin
                phase_q <= PH_RISE;
            end
        end
    end

    a_r8_no_sample_between: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FALL) |=> $stable(cmd_q));

    a_r9_stop_blocks_cmd: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RISE && stop_req && !hold) |=> !cmd_q.vld);

    a_r9_hold_keeps_phase: assert property (@(posedge clk) disable iff (rst)
        hold |=> (phase_q == PH_RISE));

    a_r6_second_beat_addr: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FALL && act_q.vld) |-> (beat_addr == ($past(beat_addr) ^ LSB_FLIP)));

endmodule

// File: rtl/b2sram_array.sv
module b2sram_array
    import b2sram_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [AW-1:0]                addr,
    input  logic [DW-1:0]                wdata,
    input  logic [lane_count(DW)-1:0]    wmask_n,
    output logic [DW-1:0]                rdata
);

    localparam int NB    = lane_count(DW);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !wmask_n[b]) begin
                lane_mem[addr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[addr];

        a_r5_lane_written: assert property (@(posedge clk) disable iff (rst)
            (we && !wmask_n[b]) |=> (lane_mem[$past(addr)] == $past(wdata[b*BYTE_W +: BYTE_W])));

        a_r5_lane_kept: assert property (@(posedge clk) disable iff (rst)
            (we && wmask_n[b]) |=> (lane_mem[$past(addr)] == $past(rdata[b*BYTE_W +: BYTE_W])));
    end

endmodule

// File: rtl/b2sram_dq.sv
module b2sram_dq
    import b2sram_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          beat_vld,
    input  op_e           beat_op,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
        end else if (!hold) begin
            if (beat_vld && beat_op == OP_RD) begin
                bus_out <= rdata;
                bus_oe  <= 1'b1;
            end else begin
                bus_oe  <= 1'b0;
            end
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bus_oe);

    a_r3_read_drives_bus: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && beat_op == OP_RD && !hold) |=> bus_oe);

    a_r2_idle_tristate: assert property (@(posedge clk) disable iff (rst)
        (!beat_vld && !hold) |=> !bus_oe);

    a_r9_bus_frozen: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(bus_out) && $stable(bus_oe)));

endmodule

// File: rtl/b2sram_top.sv
module b2sram_top
    import b2sram_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_load_n,
    input  logic                      cmd_read,
    input  logic                      stop_req,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             bus_in,
    input  logic [DW/BYTE_W-1:0]      wr_byte_n,
    output logic [DW-1:0]             bus_out,
    output logic                      bus_oe
);

    logic          beat_vld;
    op_e           beat_op;
    logic [AW-1:0] beat_addr;
    logic          hold;
    logic [DW-1:0] rdata;
    logic          we;

    b2sram_ctrl #(.AW(AW)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_load_n (cmd_load_n),
        .cmd_read   (cmd_read),
        .stop_req   (stop_req),
        .addr       (addr),
        .beat_vld   (beat_vld),
        .beat_op    (beat_op),
        .beat_addr  (beat_addr),
        .hold       (hold)
    );

    assign we = beat_vld && (beat_op == OP_WR) && !hold;

    b2sram_array #(.DW(DW), .AW(AW)) array_i (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .addr    (beat_addr),
        .wdata   (bus_in),
        .wmask_n (wr_byte_n),
        .rdata   (rdata)
    );

    b2sram_dq #(.DW(DW)) dq_i (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .beat_vld (beat_vld),
        .beat_op  (beat_op),
        .rdata    (rdata),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe)
    );

endmodule

// File: tb/b2sram_top_tb_top.sv
module b2sram_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 36;
    localparam int AW = 6;
    localparam int NB = DW / 9;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] a;
        logic [DW-1:0] d0;
        logic [NB-1:0] m0;
        logic [DW-1:0] d1;
        logic [NB-1:0] m1;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd4,  36'h1A2B3C4D5, 4'b0000, 36'h0F1E2D3C4, 4'b0000},
        '{1'b0, 6'd10, 36'h123456789, 4'b0000, 36'h987654321, 4'b0000},
        '{1'b1, 6'd4,  36'h0,         4'b1111, 36'h0,         4'b1111},
        '{1'b1, 6'd5,  36'h0,         4'b1111, 36'h0,         4'b1111},
        '{1'b0, 6'd5,  36'hFFFFFFFFF, 4'b0011, 36'h000000000, 4'b1111},
        '{1'b1, 6'd4,  36'h0,         4'b1111, 36'h0,         4'b1111},
        '{1'b0, 6'd11, 36'h0AAAAAAAA, 4'b1110, 36'h155555555, 4'b1010},
        '{1'b1, 6'd10, 36'h0,         4'b1111, 36'h0,         4'b1111},
        '{1'b1, 6'd11, 36'h0,         4'b1111, 36'h0,         4'b1111},
        '{1'b1, 6'd5,  36'h0,         4'b1111, 36'h0,         4'b1111}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_load_n = 1'b1;
    logic          cmd_read = 1'b0;
    logic          stop_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] bus_in = '0;
    logic [NB-1:0] wr_byte_n = '1;
    logic [DW-1:0] bus_out;
    logic          bus_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [1 << AW];
    logic          s_oe0, s_oe1;
    logic [DW-1:0] s_q0, s_q1;

    always #10 clk = ~clk;

    b2sram_top #(.DW(DW), .AW(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_load_n (cmd_load_n),
        .cmd_read   (cmd_read),
        .stop_req   (stop_req),
        .addr       (addr),
        .bus_in     (bus_in),
        .wr_byte_n  (wr_byte_n),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] flip(input logic [AW-1:0] a);
        return a ^ {{(AW-1){1'b0}}, 1'b1};
    endfunction

    task automatic ref_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] m);
        for (int b = 0; b < NB; b++) begin
            if (!m[b]) ref_mem[a][b*9 +: 9] = d[b*9 +: 9];
        end
    endtask

    // one command cycle: command edge then the edge between; starts and ends just after a falling clk
    task automatic kcycle(input logic ld_n, input logic rd, input logic stp, input logic [AW-1:0] a,
                          input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                          input logic [DW-1:0] d1, input logic [NB-1:0] m1, input logic ld1_n);
        cmd_load_n = ld_n; cmd_read = rd; stop_req = stp; addr = a;
        bus_in = d0; wr_byte_n = m0;
        @(posedge clk); @(negedge clk);
        s_oe0 = bus_oe; s_q0 = bus_out;
        cmd_load_n = ld1_n; cmd_read = 1'b1; addr = ~a;
        bus_in = d1; wr_byte_n = m1;
        @(posedge clk); @(negedge clk);
        s_oe1 = bus_oe; s_q1 = bus_out;
        cmd_load_n = 1'b1; wr_byte_n = '1;
    endtask

    task automatic nop_cycle();
        kcycle(1'b1, 1'b0, 1'b0, '0, '0, '1, '0, '1, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 oe during reset", {35'b0, bus_oe}, '0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 oe after reset", {35'b0, bus_oe}, '0);
        // R1: this second edge after reset must still be the between-edge, so it is idle;
        // realign to a command edge with a full nop cycle
        @(posedge clk); @(negedge clk);
        nop_cycle();

        // table walk: each vector is a command cycle followed by its data cycle
        for (int vi = 0; vi < NV; vi++) begin
            kcycle(1'b0, VECS[vi].rd, 1'b0, VECS[vi].a, '0, '1, '0, '1, 1'b1);
            check("R2 idle beat0 oe", {35'b0, s_oe0}, '0);
            check("R2 idle beat1 oe", {35'b0, s_oe1}, '0);
            kcycle(1'b1, 1'b0, 1'b0, '0, VECS[vi].d0, VECS[vi].m0, VECS[vi].d1, VECS[vi].m1, 1'b1);
            if (VECS[vi].rd) begin
                check("R3 read oe", {35'b0, s_oe0 & s_oe1}, 36'd1);
                check(vi >= 5 ? "R5 beat0 bytes" : "R3 beat0 data", s_q0, ref_mem[VECS[vi].a]);
                check(vi >= 5 ? "R5 beat1 bytes" : "R6 beat1 data", s_q1, ref_mem[flip(VECS[vi].a)]);
            end else begin
                check("R4 bus free during write data", {35'b0, s_oe0 | s_oe1}, '0);
                ref_write(VECS[vi].a, VECS[vi].d0, VECS[vi].m0);
                ref_write(flip(VECS[vi].a), VECS[vi].d1, VECS[vi].m1);
            end
        end

        // R7: read in the cycle right after a write to the same address
        kcycle(1'b0, 1'b0, 1'b0, 6'd20, '0, '1, '0, '1, 1'b1);
        kcycle(1'b0, 1'b1, 1'b0, 6'd20, 36'h0CAFEF00D, 4'b0000, 36'h0DEADBEEF, 4'b0000, 1'b1);
        ref_write(6'd20, 36'h0CAFEF00D, 4'b0000);
        ref_write(6'd21, 36'h0DEADBEEF, 4'b0000);
        nop_cycle();
        check("R7 beat0 new data", s_q0, ref_mem[20]);
        check("R7 beat1 new data", s_q1, ref_mem[21]);
        nop_cycle();

        // R10: back-to-back reads
        kcycle(1'b0, 1'b1, 1'b0, 6'd4, '0, '1, '0, '1, 1'b1);
        kcycle(1'b0, 1'b1, 1'b0, 6'd10, '0, '1, '0, '1, 1'b1);
        check("R10 first burst oe", {35'b0, s_oe0 & s_oe1}, 36'd1);
        check("R10 first burst data", s_q0, ref_mem[4]);
        nop_cycle();
        check("R10 second burst oe", {35'b0, s_oe0 & s_oe1}, 36'd1);
        check("R10 second burst data", s_q1, ref_mem[11]);
        nop_cycle();
        check("R10 oe falls after last burst", {35'b0, s_oe0 | s_oe1}, '0);

        // R8: strobe low on the between-edge is ignored
        kcycle(1'b1, 1'b1, 1'b0, 6'd4, '0, '1, '0, '1, 1'b0);
        nop_cycle();
        check("R8 between-edge strobe ignored", {35'b0, s_oe0 | s_oe1}, '0);

        // R9: stop drains a pending read, then freezes the bus
        kcycle(1'b0, 1'b1, 1'b0, 6'd4, '0, '1, '0, '1, 1'b1);
        kcycle(1'b1, 1'b0, 1'b1, '0, '0, '1, '0, '1, 1'b1);
        check("R9 drain beat0", s_q0, ref_mem[4]);
        check("R9 drain beat1", s_q1, ref_mem[5]);
        cmd_load_n = 1'b0; cmd_read = 1'b1; addr = 6'd10; stop_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check("R9 frozen oe", {35'b0, bus_oe}, 36'd1);
            check("R9 frozen data", bus_out, ref_mem[5]);
        end
        cmd_load_n = 1'b1; stop_req = 1'b0;
        nop_cycle();
        check("R9 read during stop ignored", {35'b0, s_oe0 | s_oe1}, '0);
        kcycle(1'b0, 1'b1, 1'b0, 6'd10, '0, '1, '0, '1, 1'b1);
        nop_cycle();
        check("R9 resumes on command edge", s_q0, ref_mem[10]);

        finish_run();
    end

endmodule